// File: doc/BRIEF.md
# Ordering Table Clear DMA

This block is a single-channel DMA engine that builds an empty display ordering table in word memory. Software programs a start byte address, a word count and a control word through a small register window. When the control word is written with the one supported mode value, the engine walks downward from the start address and issues one word write per accepted handshake. Each word holds a 24-bit pointer to the word just below it. The lowest word of the region receives an end-of-list marker instead of a pointer.

When the walk ends, the engine clears the busy bit in the control register and pulses its completion interrupt. A control write that has the busy bit set but carries any other value performs no memory writes, yet it still completes the channel and raises the interrupt. While the channel is busy, register writes are ignored. The one exception is a control write with the busy bit clear, which aborts the walk silently.

Top module: `otc_dma`

## Requirements
- R1: After synchronous reset, no memory write is requested, the interrupt is low and all three registers read as zero.
- R2: The register window places the start address at offset 0x0, the word count (low 16 bits) at offset 0x4 and the control word at offset 0x8, and each reads back the value last written while idle.
- R3: A transfer starts only on a control write, while idle, of exactly 0x11000002; bit 24 of the control word is the busy flag. A control write with bit 24 clear while idle only stores the value. While running, the write address and data are held until `mem_ready` accepts them, and the address then steps down by 4.
- R4: For N ≥ 1 words, the word written at address A − 4k (k < N − 1) holds (A − 4k − 4) masked to its low 24 bits, zero-extended to 32 bits.
- R5: Exactly N words are written, and the lowest one, at A − 4(N − 1), holds 0x00FFFFFF.
- R6: A word count of zero writes only 0x00FFFFFF at the start address, then completes.
- R7: One cycle after the final accepted write, `irq` is high for one cycle and control bit 24 reads as zero.
- R8: A control write, while idle, with bit 24 set and a value other than 0x11000002 makes no memory write, stores the value with bit 24 cleared and pulses `irq` once.
- R9: While busy, writes to the address and count registers and control writes with bit 24 set are ignored; readback is unchanged and the transfer continues.
- R10: A control write with bit 24 clear while busy stops the transfer at once, clears bit 24 and raises no interrupt.
- R11: The low two bits of the start address are treated as zero for the walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr`, combinational |
| mem_valid | output | 1 | Memory write request |
| mem_ready | input | 1 | Memory accepts the write in this cycle |
| mem_addr | output | 32 | Byte address of the word write |
| mem_data | output | 32 | Word write data |
| irq | output | 1 | Completion interrupt, one-cycle pulse |

## Verification
The hardest situations to reach from the ports are the ones where software writes to a channel that is still running. The bench can only create them if the walk is guaranteed to be mid-flight. It therefore holds `mem_ready` low, which freezes the engine with a request pending. It then issues the ignored writes and the aborting write, and reads the register window back before it releases `mem_ready`. Address arithmetic that wraps below zero and the 24-bit mask are reached by choosing start addresses near zero and just above 0x01000000. Those runs also use pseudo-random ready stalls.

// File: rtl/otc_pkg.sv
package otc_pkg;
    localparam int          DATA_W     = 32;
    localparam int          OFF_W      = 4;
    localparam int          BUSY_BIT   = 24;
    localparam logic [3:0]  OFF_BASE   = 4'h0;
    localparam logic [3:0]  OFF_COUNT  = 4'h4;
    localparam logic [3:0]  OFF_CTRL   = 4'h8;
    localparam logic [31:0] MODE_CLEAR = 32'h1100_0002;
    localparam logic [23:0] END_MARK   = 24'hFF_FFFF;

    typedef enum logic {W_IDLE, W_RUN} walk_state_e;

    typedef struct packed {
        logic start;
        logic abort;
    } walk_cmd_t;

    function automatic logic [23:0] link_of(input logic [23:0] addr);
        return addr - 24'd4;
    endfunction
endpackage

// File: rtl/otc_regs.sv
module otc_regs
    import otc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [OFF_W-1:0]  off,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              busy,
    input  logic              done,
    output logic [ADDR_W-3:0] base_word,
    output logic [CNT_W-1:0]  count,
    output walk_cmd_t         cmd,
    output logic              irq
);
    logic [ADDR_W-1:0] base_q;
    logic [DATA_W-1:0] ctrl_q;
    logic              ctrl_hit, kick, bypass;

    assign ctrl_hit  = wr_en && (off == OFF_CTRL);
    assign kick      = ctrl_hit && !busy && wdata[BUSY_BIT];
    assign cmd.start = kick && (wdata == MODE_CLEAR);
    assign bypass    = kick && (wdata != MODE_CLEAR);
    assign cmd.abort = ctrl_hit && busy && !wdata[BUSY_BIT];
    assign base_word = base_q[ADDR_W-1:2];

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            count  <= '0;
            ctrl_q <= '0;
            irq    <= 1'b0;
        end else begin
            irq <= done | bypass;
            if (wr_en && !busy && off == OFF_BASE)
                base_q <= wdata[ADDR_W-1:0];
            if (wr_en && !busy && off == OFF_COUNT)
                count <= wdata[CNT_W-1:0];
            if (ctrl_hit && !busy) begin
                ctrl_q <= wdata;
                if (bypass)
                    ctrl_q[BUSY_BIT] <= 1'b0;
            end
            if (cmd.abort || done)
                ctrl_q[BUSY_BIT] <= 1'b0;
        end
    end

    always_comb begin
        rdata = '0;
        case (off)
            OFF_BASE:  rdata[ADDR_W-1:0] = base_q;
            OFF_COUNT: rdata[CNT_W-1:0]  = count;
            OFF_CTRL:  rdata             = ctrl_q;
            default:   rdata             = '0;
        endcase
    end

    // R3: a running walk always shows the busy flag
    p_busy_flag_r3: assert property (@(posedge clk) disable iff (rst)
        busy |-> ctrl_q[BUSY_BIT]);
    // R7: completion clears the flag and raises the interrupt
    p_done_clears_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> (!ctrl_q[BUSY_BIT] && irq));
    // R8: unsupported mode completes without walking
    p_bypass_r8: assert property (@(posedge clk) disable iff (rst)
        bypass |=> (irq && !ctrl_q[BUSY_BIT] && !busy));
    // R9: address register is frozen while busy
    p_busy_ignore_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && wr_en && off == OFF_BASE) |=> $stable(base_q));
    // R10: abort is silent
    p_abort_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        cmd.abort |=> (!irq && !ctrl_q[BUSY_BIT]));
endmodule

// File: rtl/otc_walker.sv
module otc_walker
    import otc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  walk_cmd_t         cmd,
    input  logic [ADDR_W-3:0] base_word,
    input  logic [CNT_W-1:0]  count,
    input  logic              mem_ready,
    output logic              mem_valid,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_data,
    output logic              busy,
    output logic              done
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);
    localparam logic [CNT_W-1:0]  ONE  = CNT_W'(1);

    walk_state_e       state;
    logic [ADDR_W-1:0] cur;
    logic [CNT_W-1:0]  rem;
    logic              last;

    assign busy      = (state == W_RUN);
    assign mem_valid = busy;
    assign mem_addr  = cur;
    assign last      = (rem == ONE);
    assign done      = busy && mem_ready && last && !cmd.abort;

    always_comb begin
        mem_data = '0;
        mem_data[23:0] = last ? END_MARK : link_of(cur[23:0]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= W_IDLE;
            cur   <= '0;
            rem   <= '0;
        end else if (cmd.abort) begin
            state <= W_IDLE;
        end else begin
            case (state)
                W_IDLE: if (cmd.start) begin
                    state <= W_RUN;
                    cur   <= {base_word, 2'b00};
                    rem   <= (count == '0) ? ONE : count;
                end
                W_RUN: if (mem_ready) begin
                    cur <= cur - STEP;
                    rem <= rem - ONE;
                    if (last)
                        state <= W_IDLE;
                end
                default: state <= W_IDLE;
            endcase
        end
    end

    // R3: request is held while stalled
    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ready && !cmd.abort) |=>
            (mem_valid && $stable(mem_addr) && $stable(mem_data)));
    // R3: accepted non-final write steps the address down one word
    p_step_r3: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && mem_ready && !last && !cmd.abort) |=>
            (mem_valid && mem_addr == $past(mem_addr) - STEP));
    // R4: successive pointers descend by one word
    p_link_r4: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && mem_ready && rem > CNT_W'(2) && !cmd.abort) |=>
            (mem_data[23:0] == $past(mem_data[23:0]) - 24'd4 && mem_data[31:24] == 8'h00));
    // R11: writes are word aligned
    p_align_r11: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> (mem_addr[1:0] == 2'b00));
endmodule

// File: rtl/otc_dma.sv
module otc_dma
    import otc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [3:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_data,
    output logic              irq
);
    walk_cmd_t         cmd;
    logic [ADDR_W-3:0] base_word;
    logic [CNT_W-1:0]  count;
    logic              busy, done;

    otc_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst(rst), .wr_en(reg_wr), .off(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .busy(busy), .done(done),
        .base_word(base_word), .count(count), .cmd(cmd), .irq(irq)
    );

    otc_walker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_walk (
        .clk(clk), .rst(rst), .cmd(cmd), .base_word(base_word),
        .count(count), .mem_ready(mem_ready), .mem_valid(mem_valid),
        .mem_addr(mem_addr), .mem_data(mem_data), .busy(busy), .done(done)
    );
endmodule

// File: tb/sim_otc_dma.sv
module sim_otc_dma;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] MODE = 32'h1100_0002;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = 4'h0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_valid;
    logic        mem_ready = 1'b0;
    logic [31:0] mem_addr;
    logic [31:0] mem_data;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    int cyc = 0;
    int n_wr = 0;
    int n_irq = 0;
    int last_acc = 0;
    int irq_at = 0;
    logic [31:0] log_a [256];
    logic [31:0] log_d [256];
    int rdy_mode = 0;
    logic [7:0] lfsr = 8'hA5;

    otc_dma u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_valid(mem_valid),
        .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        case (rdy_mode)
            0:       mem_ready <= 1'b1;
            1:       mem_ready <= 1'b0;
            default: mem_ready <= lfsr[0];
        endcase
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst) begin
            if (mem_valid && mem_ready) begin
                if (n_wr < 256) begin
                    log_a[n_wr] <= mem_addr;
                    log_d[n_wr] <= mem_data;
                end
                n_wr <= n_wr + 1;
                last_acc <= cyc;
            end
            if (irq) begin
                n_irq <= n_irq + 1;
                irq_at <= cyc;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] c;
        for (int i = 0; i < 3000; i++) begin
            reg_read(4'h8, c);
            if (!c[24]) break;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic check_log(input string tag, input logic [31:0] base, input int cnt,
                             input int w0, input int i0);
        int nw;
        logic [31:0] ea, ed, c;
        nw = (cnt == 0) ? 1 : cnt;
        chk(n_wr - w0 == nw, {tag, " R5 word count"}, n_wr - w0, nw);
        for (int k = 0; k < nw; k++) begin
            ea = (base & 32'hFFFF_FFFC) - 32'(4 * k);
            ed = (k == nw - 1) ? 32'h00FF_FFFF : ((ea - 32'd4) & 32'h00FF_FFFF);
            chk(log_a[w0 + k] == ea, {tag, " R3 address"}, log_a[w0 + k], ea);
            chk(log_d[w0 + k] == ed, {tag, " R4/R5 data"}, log_d[w0 + k], ed);
        end
        chk(n_irq - i0 == 1, {tag, " R7 irq count"}, n_irq - i0, 1);
        chk(irq_at == last_acc + 1, {tag, " R7 irq timing"}, irq_at, last_acc + 1);
        reg_read(4'h8, c);
        chk(!c[24], {tag, " R7 busy cleared"}, c, c & ~32'h0100_0000);
    endtask

    task automatic run_xfer(input string tag, input logic [31:0] base, input int cnt, input int mode);
        int w0, i0;
        rdy_mode = mode;
        reg_write(4'h0, base);
        reg_write(4'h4, 32'(cnt));
        w0 = n_wr; i0 = n_irq;
        reg_write(4'h8, MODE);
        wait_idle();
        check_log(tag, base, cnt, w0, i0);
        rdy_mode = 0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk(mem_valid == 1'b0, "R1 mem_valid", 32'(mem_valid), 0);
        chk(irq == 1'b0, "R1 irq", 32'(irq), 0);
        for (int a = 0; a < 3; a++) begin
            reg_read(4'(a * 4), d);
            chk(d == 0, "R1 register zero", d, 0);
        end
    endtask

    task automatic t_regs();
        logic [31:0] d;
        int w0, i0;
        w0 = n_wr; i0 = n_irq;
        reg_write(4'h0, 32'h0000_1234);
        reg_write(4'h4, 32'h0000_0005);
        reg_write(4'h8, 32'h0000_0002);
        repeat (4) @(negedge clk);
        reg_read(4'h0, d); chk(d == 32'h1234, "R2 address readback", d, 32'h1234);
        reg_read(4'h4, d); chk(d == 32'h5, "R2 count readback", d, 32'h5);
        reg_read(4'h8, d); chk(d == 32'h2, "R2 control readback", d, 32'h2);
        chk(n_wr == w0, "R3 no start without busy bit", n_wr - w0, 0);
        chk(n_irq == i0, "R3 no irq without busy bit", n_irq - i0, 0);
    endtask

    task automatic t_badmode(input logic [31:0] v);
        logic [31:0] d;
        int w0, i0;
        w0 = n_wr; i0 = n_irq;
        reg_write(4'h8, v);
        repeat (4) @(negedge clk);
        chk(n_wr == w0, "R8 no memory write", n_wr - w0, 0);
        chk(n_irq - i0 == 1, "R8 irq pulse", n_irq - i0, 1);
        reg_read(4'h8, d);
        chk(d == (v & ~32'h0100_0000), "R8 control stored, busy clear", d, v & ~32'h0100_0000);
    endtask

    task automatic t_busy_ignore();
        logic [31:0] d;
        int w0, i0;
        rdy_mode = 1;
        reg_write(4'h0, 32'h300);
        reg_write(4'h4, 32'd3);
        w0 = n_wr; i0 = n_irq;
        reg_write(4'h8, MODE);
        reg_write(4'h0, 32'h999);
        reg_write(4'h4, 32'd7);
        reg_write(4'h8, 32'h0100_0003);
        reg_read(4'h0, d); chk(d == 32'h300, "R9 address unchanged", d, 32'h300);
        reg_read(4'h4, d); chk(d == 32'd3, "R9 count unchanged", d, 32'd3);
        reg_read(4'h8, d); chk(d == MODE, "R9 control unchanged", d, MODE);
        chk(mem_valid == 1'b1, "R9 still running", 32'(mem_valid), 1);
        rdy_mode = 0;
        wait_idle();
        check_log("R9 continue", 32'h300, 3, w0, i0);
    endtask

    task automatic t_abort();
        logic [31:0] d;
        int w0, i0;
        rdy_mode = 1;
        reg_write(4'h0, 32'h500);
        reg_write(4'h4, 32'd8);
        w0 = n_wr; i0 = n_irq;
        reg_write(4'h8, MODE);
        repeat (3) @(negedge clk);
        reg_write(4'h8, 32'h0000_0000);
        #1 chk(mem_valid == 1'b0, "R10 request dropped", 32'(mem_valid), 0);
        rdy_mode = 0;
        repeat (12) @(negedge clk);
        chk(n_wr == w0, "R10 no writes after abort", n_wr - w0, 0);
        chk(n_irq == i0, "R10 no irq on abort", n_irq - i0, 0);
        reg_read(4'h8, d);
        chk(!d[24], "R10 busy cleared", d, d & ~32'h0100_0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_regs();
        run_xfer("R3 basic", 32'h0000_0100, 4, 0);
        run_xfer("R4 wrap below zero", 32'h0000_0010, 6, 2);
        run_xfer("R4 24-bit mask", 32'h0100_0008, 3, 2);
        run_xfer("R6 zero count", 32'h0000_0200, 0, 0);
        run_xfer("R11 unaligned start", 32'h0000_0203, 2, 0);
        t_badmode(32'h1100_0001);
        t_badmode(32'h0100_0002);
        t_busy_ignore();
        t_abort();
        run_xfer("R10 restart after abort", 32'h0000_0040, 1, 2);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL all watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule